// File: doc/BRIEF.md
# Gated Multichannel Conversion Sequencer

This block sequences twelve charge-integrating converter channels that share one run-down counter. A channel takes part in a conversion once its gate input has been seen. After a start pulse the shared counter runs for a fixed number of cycles. Each gated channel follows the counter for as long as its comparator reports run-down activity. It keeps the last count it saw, saturated to ten bits, and raises an overflow flag if the count went past full scale. When the counter window closes, end of conversion is raised and stays high until the block is cleared.

A fast clear input aborts everything, including a conversion in flight. It takes effect only after it has been held for a minimum number of cycles. A settling lockout follows it, and during that lockout both start and gates are refused. Gates are not self-locking: a channel can be gated any number of times before a clear. A crate inhibit blocks gates. A threshold input, clamped to 100 counts, is compared with every result once conversion ends. If no channel reaches it, the module is flagged empty so that readout can skip it.

Top module: `conv_seq_top`

## Requirements
- R1: After reset every channel word is zero, end of conversion, empty and converting are low, and ready is high.
- R2: A start seen while ready begins a conversion of CONV_CYCLES cycles. The counter is 0 in the first converting cycle and rises by one each cycle. End of conversion then rises and stays high until a clear.
- R3: Each channel word is 11 bits: bits 9:0 hold the value and bit 10 holds overflow. Channel k occupies data_o[11k+10:11k]. A gated channel holds the last counter value seen while its run-down input was high, limited to 1023. Overflow is set when that value exceeded 1023.
- R4: A channel with no accepted gate since the last clear reads 0 with overflow clear, whatever its run-down input does.
- R5: A gate is accepted in any ready or converting cycle, including after gates the channel has already received. A gate that arrives during conversion lets the channel track from the next cycle on.
- R6: A gate presented while inhibit is high has no effect.
- R7: Fast clear acts on the CLR_MIN-th consecutive high cycle and zeroes all channels and end of conversion, even mid-conversion. Shorter pulses change nothing.
- R8: After the last clear cycle, start and gates are refused for SETTLE_CYCLES cycles, and ready is low during that time.
- R9: Empty is high only after end of conversion, and only when every channel value is below min(threshold, 100). A threshold of 0 never flags empty.
- R10: Start is ignored while converting or after end of conversion. Channel words do not change after end of conversion.
- R11: A clear that qualifies in the last conversion cycle wins, and end of conversion does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts the shared counter |
| fclr_i | input | 1 | Fast clear, level held |
| inhibit_i | input | 1 | Blocks gate inputs |
| gate_i | input | 12 | Per-channel gate |
| rundown_i | input | 12 | Per-channel comparator run-down active |
| thresh_i | input | 7 | Empty threshold in counts |
| data_o | output | 132 | Channel words, 11 bits each |
| eoc_o | output | 1 | End of conversion |
| empty_o | output | 1 | All channels below threshold |
| ready_o | output | 1 | Armed for gates and start |
| conv_o | output | 1 | Conversion in progress |

## Verification
Two functions can land on the same clock edge: the end of the conversion window and the qualification of a fast clear. The bench lines them up by raising the clear three cycles before the counter's last value. It then requires the block to go straight into the settling lockout, with end of conversion never rising and all words at zero. A second pairing comes from a gate that arrives while inhibit is high and is then repeated once inhibit is low. The bench judges it by the final value of that channel.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_RUN    = 2'd1,
    ST_HOLD   = 2'd2,
    ST_SETTLE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/cs_timer.sv
module cs_timer
  import cs_pkg::*;
#(
  parameter int CONV_CYCLES   = 3000,
  parameter int SETTLE_CYCLES = 75,
  parameter int CLR_MIN       = 3,
  localparam int CW = $clog2(CONV_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          fclr_i,
  output seq_state_t    state_o,
  output logic [CW-1:0] cnt_o,
  output logic          clr_o
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int RW = $clog2(CLR_MIN + 1);
  localparam logic [CW-1:0] LAST  = CW'(CONV_CYCLES - 1);
  localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYCLES - 1);
  localparam logic [RW-1:0] RMAX  = RW'(CLR_MIN);
  localparam logic [RW-1:0] RQUAL = RW'(CLR_MIN - 1);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic [RW-1:0] run_q, run_d;
  logic          clr_hit;

  always_comb begin
    clr_hit = fclr_i && (run_q >= RQUAL);
    run_d   = !fclr_i ? '0 : ((run_q == RMAX) ? run_q : run_q + 1'b1);
    st_d    = st_q;
    cnt_d   = cnt_q;
    scnt_d  = scnt_q;
    if (clr_hit) begin
      st_d   = ST_SETTLE;
      cnt_d  = '0;
      scnt_d = '0;
    end else begin
      case (st_q)
        ST_ARMED: if (start_i) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST) st_d = ST_HOLD;
          else cnt_d = cnt_q + 1'b1;
        end
        ST_SETTLE: begin
          if (scnt_q == SLAST) st_d = ST_ARMED;
          else scnt_d = scnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ARMED;
      cnt_q  <= '0;
      scnt_q <= '0;
      run_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      scnt_q <= scnt_d;
      run_q  <= run_d;
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
  assign clr_o   = clr_hit;

  p_window_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cnt_q == LAST && !clr_hit) |=> st_q == ST_HOLD);
  p_eoc_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !clr_hit) |=> st_q == ST_HOLD);
  p_settle_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETTLE) |=> st_q != ST_RUN);
  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> st_q == ST_SETTLE);
endmodule

// File: rtl/cs_channel.sv
module cs_channel #(
  parameter int VAL_W = 10,
  parameter int CW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             accept_i,
  input  logic             gate_i,
  input  logic             run_i,
  input  logic             rundown_i,
  input  logic [CW-1:0]    cnt_i,
  output logic [VAL_W-1:0] val_o,
  output logic             ovf_o
);
  localparam int MAXV = (1 << VAL_W) - 1;

  logic             hit_q, hit_d;
  logic [VAL_W-1:0] val_q, val_d;
  logic             ovf_q, ovf_d;
  logic             upd_en, over;

  always_comb begin
    over   = int'(cnt_i) > MAXV;
    upd_en = run_i && hit_q && rundown_i;
    hit_d  = hit_q | (accept_i & gate_i);
    val_d  = over ? VAL_W'(MAXV) : VAL_W'(cnt_i);
    ovf_d  = over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      val_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      hit_q <= 1'b0;
      val_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      if (upd_en) begin
        val_q <= val_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign val_o = val_q;
  assign ovf_o = ovf_q;

  p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (val_q == '0 && !ovf_q));
  p_nogate_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_q |-> (val_q == '0 && !ovf_q));
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(val_q));
  p_ovf_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> val_q == VAL_W'(MAXV));
endmodule

// File: rtl/cs_empty.sv
module cs_empty #(
  parameter int N_CH    = 12,
  parameter int VAL_W   = 10,
  parameter int THR_W   = 7,
  parameter int THR_MAX = 100
) (
  input  logic [N_CH*VAL_W-1:0] vals_i,
  input  logic [THR_W-1:0]      thr_i,
  input  logic                  hold_i,
  output logic                  empty_o
);
  int   thr_eff;
  logic all_low;

  always_comb begin
    thr_eff = (int'(thr_i) > THR_MAX) ? THR_MAX : int'(thr_i);
    all_low = 1'b1;
    for (int k = 0; k < N_CH; k++) begin
      if (int'(vals_i[k*VAL_W +: VAL_W]) >= thr_eff) all_low = 1'b0;
    end
    empty_o = hold_i && all_low;
  end
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
  import cs_pkg::*;
#(
  parameter int N_CH          = 12,
  parameter int VAL_W         = 10,
  parameter int CONV_CYCLES   = 3000,
  parameter int SETTLE_CYCLES = 75,
  parameter int CLR_MIN       = 3,
  parameter int THR_W         = 7,
  parameter int THR_MAX       = 100
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      fclr_i,
  input  logic                      inhibit_i,
  input  logic [N_CH-1:0]           gate_i,
  input  logic [N_CH-1:0]           rundown_i,
  input  logic [THR_W-1:0]          thresh_i,
  output logic [N_CH*(VAL_W+1)-1:0] data_o,
  output logic                      eoc_o,
  output logic                      empty_o,
  output logic                      ready_o,
  output logic                      conv_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int WW = VAL_W + 1;

  seq_state_t            st;
  logic [CW-1:0]         cnt;
  logic                  clr;
  logic                  accept;
  logic [N_CH*VAL_W-1:0] vals;

  cs_timer #(
    .CONV_CYCLES  (CONV_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .CLR_MIN      (CLR_MIN)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .fclr_i (fclr_i),
    .state_o(st),
    .cnt_o  (cnt),
    .clr_o  (clr)
  );

  assign accept = (st == ST_ARMED || st == ST_RUN) && !inhibit_i;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [VAL_W-1:0] v;
    logic             o;
    cs_channel #(.VAL_W(VAL_W), .CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clr),
      .accept_i (accept),
      .gate_i   (gate_i[k]),
      .run_i    (st == ST_RUN),
      .rundown_i(rundown_i[k]),
      .cnt_i    (cnt),
      .val_o    (v),
      .ovf_o    (o)
    );
    assign data_o[k*WW +: WW]       = {o, v};
    assign vals[k*VAL_W +: VAL_W]   = v;
  end

  cs_empty #(
    .N_CH(N_CH), .VAL_W(VAL_W), .THR_W(THR_W), .THR_MAX(THR_MAX)
  ) u_empty (
    .vals_i (vals),
    .thr_i  (thresh_i),
    .hold_i (st == ST_HOLD),
    .empty_o(empty_o)
  );

  assign eoc_o   = (st == ST_HOLD);
  assign ready_o = (st == ST_ARMED);
  assign conv_o  = (st == ST_RUN);

  p_empty_after_eoc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> eoc_o);
endmodule

// File: tb/conv_seq_top_test.sv
module conv_seq_top_test;
  localparam int N = 12;
  localparam int CONV = 3000;
  localparam int SETL = 75;
  localparam int CMIN = 3;
  localparam int TMAX = 100;

  logic clk = 1'b0;
  logic rst_n;
  logic start, fclr, inhibit;
  logic [N-1:0] gate, rd;
  logic [6:0] thr;
  logic [N*11-1:0] data;
  logic eoc, empty, ready, conv;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int len [N];

  // behavioural reference state: 0 ready, 1 converting, 2 done, 3 settling
  int m_st, m_cnt, m_scnt, m_run;
  int m_val [N];
  bit m_ovf [N];
  bit m_hit [N];
  logic m_clr;

  always #10 clk = ~clk;

  conv_seq_top uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fclr_i(fclr),
    .inhibit_i(inhibit), .gate_i(gate), .rundown_i(rd), .thresh_i(thr),
    .data_o(data), .eoc_o(eoc), .empty_o(empty), .ready_o(ready), .conv_o(conv)
  );

  always_comb
    for (int k = 0; k < N; k++) rd[k] = (m_st == 1) && (m_cnt < len[k]);

  assign m_clr = fclr && (m_run >= CMIN - 1);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_scnt <= 0; m_run <= 0;
      for (int k = 0; k < N; k++) begin m_val[k] <= 0; m_ovf[k] <= 0; m_hit[k] <= 0; end
    end else begin
      m_run <= fclr ? ((m_run == CMIN) ? m_run : m_run + 1) : 0;
      if (m_clr) begin
        m_st <= 3; m_cnt <= 0; m_scnt <= 0;
        for (int k = 0; k < N; k++) begin m_val[k] <= 0; m_ovf[k] <= 0; m_hit[k] <= 0; end
      end else begin
        if ((m_st == 0 || m_st == 1) && !inhibit)
          for (int k = 0; k < N; k++) if (gate[k]) m_hit[k] <= 1;
        if (m_st == 1)
          for (int k = 0; k < N; k++)
            if (m_hit[k] && rd[k]) begin
              m_val[k] <= (m_cnt > 1023) ? 1023 : m_cnt;
              m_ovf[k] <= (m_cnt > 1023);
            end
        case (m_st)
          0: if (start) begin m_st <= 1; m_cnt <= 0; end
          1: if (m_cnt == CONV - 1) m_st <= 2; else m_cnt <= m_cnt + 1;
          3: if (m_scnt == SETL - 1) m_st <= 0; else m_scnt <= m_scnt + 1;
          default: ;
        endcase
      end
    end
  end

  function automatic int word(int k);
    return int'(data[k*11 +: 11]);
  endfunction

  function automatic bit m_empty();
    int t;
    t = (int'(thr) > TMAX) ? TMAX : int'(thr);
    if (m_st != 2) return 0;
    for (int k = 0; k < N; k++) if (m_val[k] >= t) return 0;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int k = 0; k < N; k++) begin
        int e;
        e = (int'(m_ovf[k]) << 10) | m_val[k];
        chk(word(k) == e, "R3 word", word(k), e);
      end
      chk(eoc == (m_st == 2), "R2 eoc", int'(eoc), int'(m_st == 2));
      chk(conv == (m_st == 1), "R2 conv", int'(conv), int'(m_st == 1));
      chk(ready == (m_st == 0), "R8 ready", int'(ready), int'(m_st == 0));
      chk(empty == m_empty(), "R9 empty", int'(empty), int'(m_empty()));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive_edge();
    @(negedge clk); #2;
  endtask

  task automatic pulse_start();
    drive_edge(); start = 1;
    drive_edge(); start = 0;
  endtask

  task automatic pulse_gate(input logic [N-1:0] m);
    drive_edge(); gate = m;
    drive_edge(); gate = '0;
  endtask

  task automatic do_clear(input int n);
    drive_edge(); fclr = 1;
    repeat (n) @(negedge clk);
    #2 fclr = 0;
  endtask

  task automatic wait_eoc();
    int t = 0;
    while (eoc !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_ready();
    int t = 0;
    while (ready !== 1'b1 && t < 500) begin @(negedge clk); t++; end
  endtask

  initial begin
    rst_n = 0; start = 0; fclr = 0; inhibit = 0; gate = '0; thr = 7'd50;
    for (int k = 0; k < N; k++) len[k] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(data == '0, "R1 data", int'(data[31:0]), 0);
    chk(ready == 1 && eoc == 0 && conv == 0 && empty == 0, "R1 flags",
        int'({ready, eoc, conv, empty}), 8);
    #2 rst_n = 1;

    // Conversion A: lengths around saturation, channel 6 ungated
    len = '{0, 1, 200, 1024, 1025, 3000, 300, 50, 60, 70, 80, 90};
    pulse_gate(12'hFBF);
    pulse_start();
    wait_eoc();
    @(negedge clk);
    chk(word(2) == 199, "R3 plain", word(2), 199);
    chk(word(3) == 1023, "R3 full no ovf", word(3), 1023);
    chk(word(4) == 2047, "R3 overflow", word(4), 2047);
    chk(word(5) == 2047, "R3 never ends", word(5), 2047);
    chk(word(0) == 0 && word(1) == 0, "R3 zero len", word(0) + word(1), 0);
    chk(word(6) == 0, "R4 ungated", word(6), 0);
    chk(empty == 0, "R9 not empty", int'(empty), 0);
    // R10: start after end of conversion is ignored
    pulse_start();
    @(negedge clk);
    chk(eoc == 1 && conv == 0, "R10 start ignored", int'({eoc, conv}), 2);
    // R7: short clear has no effect
    do_clear(CMIN - 1);
    @(negedge clk);
    chk(eoc == 1 && word(2) == 199, "R7 short clear", word(2), 199);
    do_clear(CMIN);
    @(negedge clk);
    chk(data == '0 && eoc == 0, "R7 full clear", int'(eoc), 0);
    // R8: start and gate inside the settle window refused
    pulse_gate(12'hFFF);
    pulse_start();
    chk(conv == 0 && ready == 0, "R8 lockout", int'(conv), 0);
    wait_ready();

    // Conversion B: inhibit and repeated gates
    for (int k = 0; k < N; k++) len[k] = 500;
    drive_edge(); inhibit = 1; gate = 12'h048;
    drive_edge(); inhibit = 0; gate = '0;
    pulse_gate(12'h010);
    pulse_gate(12'h010);
    pulse_start();
    while (!(m_st == 1 && m_cnt >= 100)) @(negedge clk);
    pulse_gate(12'h060);
    wait_eoc();
    @(negedge clk);
    chk(word(3) == 0, "R6 inhibited gate", word(3), 0);
    chk(word(4) == 499, "R5 repeated gate", word(4), 499);
    chk(word(5) == 499, "R5 gate during conversion", word(5), 499);
    chk(word(6) == 499, "R5 regate after inhibit", word(6), 499);
    do_clear(CMIN);
    wait_ready();

    // Conversion C: values at 100 versus clamped threshold
    for (int k = 0; k < N; k++) len[k] = 101;
    pulse_gate(12'hFFF);
    pulse_start();
    wait_eoc();
    drive_edge(); thr = 7'd127;
    @(negedge clk);
    chk(empty == 0, "R9 clamp 100", int'(empty), 0);
    drive_edge(); thr = 7'd0;
    @(negedge clk);
    chk(empty == 0, "R9 zero threshold", int'(empty), 0);
    do_clear(CMIN);
    wait_ready();

    // Conversion D: all values 9
    for (int k = 0; k < N; k++) len[k] = 10;
    pulse_gate(12'hFFF);
    pulse_start();
    wait_eoc();
    drive_edge(); thr = 7'd10;
    @(negedge clk);
    chk(empty == 1, "R9 empty", int'(empty), 1);
    drive_edge(); thr = 7'd9;
    @(negedge clk);
    chk(empty == 0, "R9 equal not empty", int'(empty), 0);
    do_clear(CMIN);
    wait_ready();

    // Conversion E: clear qualifying on the last window cycle (R11)
    for (int k = 0; k < N; k++) len[k] = 40;
    pulse_gate(12'hFFF);
    pulse_start();
    while (!(m_st == 1 && m_cnt == CONV - 3)) @(negedge clk);
    #2 fclr = 1;
    repeat (CMIN) @(negedge clk);
    #2 fclr = 0;
    @(negedge clk);
    chk(eoc == 0 && ready == 0 && conv == 0, "R11 clear wins",
        int'({eoc, ready, conv}), 0);
    chk(data == '0, "R11 words zero", int'(data[31:0]), 0);
    wait_ready();
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule